// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD registers. Each cycle in which the one-second enable is high and no host write is pending, the seconds register steps forward. A wrap ripples on in the same cycle to minutes, hours, day of week, date, month and year. Date rollover follows the length of the current month, and February gains a 29th day in every year whose two-digit value is a multiple of four.

The hour register holds its own display format. Bit 7 selects 24-hour counting. In 12-hour counting, bit 5 marks the afternoon. A host load port writes any single register in one cycle. Every register is visible at all times on its own output bus. Writing the seconds register also raises a strobe for the external prescaler, so that the next one-second enable comes a full second later.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the outputs read seconds 8'h00, minutes 8'h00, hour 8'h12 (12-hour form, bit 5 clear, so midnight), day of week 0, date 8'h01, month 8'h01 and year 8'h00.
- R2: A tick with no write advances seconds in BCD from 8'h00 to 8'h59. 8'h59 wraps to 8'h00 and advances minutes in the same cycle. Minutes count the same way, and their wrap advances the hour.
- R3: In a cycle with neither tick nor write, no output register changes.
- R4: With hour bit 7 set, bits 5:0 count BCD 00 to 23. 23 goes to 00 and advances the date and the day of week.
- R5: With hour bit 7 clear, bits 4:0 count BCD 01 to 12 and bit 5 is the PM flag. 11 goes to 12 and inverts the flag. 12 goes to 01 and leaves the flag as it is. Only 11 PM going to 12 AM advances the day.
- R6: Date 8'h30 is the last day of months 8'h04, 8'h06, 8'h09 and 8'h11. February ends at 8'h28, or at 8'h29 in a leap year. Every other month ends at 8'h31. Passing the last day sets date to 8'h01 and advances the month.
- R7: A year is a leap year when its BCD value, read as a number 0 to 99, is a multiple of 4. This includes 00.
- R8: Month 8'h12 rolls over to 8'h01 and advances the year. Year 8'h99 rolls over to 8'h00.
- R9: Day of week counts 0 to 6 and advances once per day rollover. 6 goes to 0.
- R10: With wr_en_i high, wr_sel_i picks a register: 0 seconds, 1 minutes, 2 hour, 3 day of week (low 3 data bits), 4 date, 5 month, 6 year. The value shows on the output after the next clock edge. In a write cycle a tick has no effect on any register. Select 7 changes nothing.
- R11: phase_clr_o is high, in the same cycle, exactly when wr_en_i is high with wr_sel_i equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| tick_i | input | 1 | One-second advance enable |
| wr_en_i | input | 1 | Host load strobe |
| wr_sel_i | input | 3 | Register select for the load |
| wr_data_i | input | 8 | Load data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour with mode bit 7 and PM bit 5 |
| dow_o | output | 3 | Day of week, 0 to 6 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| phase_clr_o | output | 1 | Clears the external sub-second phase on a seconds write |

## Verification
The range assertions assume the host only loads legal BCD values for each field. In 12-hour form that means an hour of 01 to 12, and a date is never loaded beyond the length of its month. The rollover assertions treat a changed register as counter-driven only when no write happened in the previous cycle. Every value the bench loads is produced by its own encoder from legal integers. Tick and write are driven together only in the cases that test write priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 3;
  localparam int NUM_REGS = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // Packed two-digit BCD increment, no wrap handling.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Last valid date of a BCD month.
  function automatic logic [BYTE_W-1:0] month_last(input logic [BYTE_W-1:0] month,
                                                   input logic leap);
    logic [BYTE_W-1:0] r;
    case (month)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter
  import rtc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FIRST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  input  logic [BYTE_W-1:0] last_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              wrap_o
);
  logic [BYTE_W-1:0] val_q, val_d;
  logic              at_last;

  assign at_last = (val_q == last_i);
  assign wrap_o  = adv_i && at_last;

  always_comb begin
    val_d = val_q;
    if (ld_i)       val_d = ld_data_i;
    else if (adv_i) val_d = at_last ? FIRST : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FIRST;
    else        val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [BYTE_W-1:0] hour_o,
  output logic              day_o
);
  localparam logic [BYTE_W-1:0] HOUR_RST = 8'h12;

  logic [BYTE_W-1:0] hour_q, hour_d;
  logic              unit_carry;
  logic [3:0]        unit_next;
  logic              mode24;
  logic              pm;

  assign mode24     = hour_q[7];
  assign pm         = hour_q[5];
  assign unit_carry = (hour_q[3:0] == 4'd9);
  assign unit_next  = unit_carry ? 4'd0 : hour_q[3:0] + 4'd1;

  always_comb begin
    hour_d = hour_q;
    day_o  = 1'b0;
    if (ld_i) begin
      hour_d = ld_data_i;
    end else if (adv_i) begin
      if (mode24) begin
        if (hour_q[5:0] == 6'h23) begin
          hour_d = 8'h80;
          day_o  = 1'b1;
        end else begin
          hour_d = {2'b10, hour_q[5:4] + {1'b0, unit_carry}, unit_next};
        end
      end else begin
        if (hour_q[4:0] == 5'h12) begin
          hour_d = {2'b00, pm, 5'h01};
        end else if (hour_q[4:0] == 5'h11) begin
          hour_d = {2'b00, ~pm, 5'h12};
          day_o  = pm;
        end else begin
          hour_d = {2'b00, pm, hour_q[4] | unit_carry, unit_next};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hour_q <= HOUR_RST;
    else        hour_q <= hour_d;
  end

  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DOW_COUNT = 7,
  localparam int DOW_W = $clog2(DOW_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_i,
  input  logic              ld_dow_i,
  input  logic              ld_date_i,
  input  logic              ld_month_i,
  input  logic              ld_year_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [DOW_W-1:0]  dow_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o
);
  localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DOW_COUNT - 1);

  logic [DOW_W-1:0]  dow_q, dow_d;
  logic              leap;
  logic [BYTE_W-1:0] date_last;
  logic              month_adv, year_adv, year_wrap_unused;

  // Tens parity decides which unit digits make a multiple of four.
  always_comb begin
    if (year_o[4]) leap = (year_o[3:0] == 4'd2) || (year_o[3:0] == 4'd6);
    else           leap = (year_o[3:0] == 4'd0) || (year_o[3:0] == 4'd4) ||
                          (year_o[3:0] == 4'd8);
  end

  assign date_last = month_last(month_o, leap);

  rtc_wrap_counter #(.FIRST(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .adv_i(day_i), .ld_i(ld_date_i),
    .ld_data_i(ld_data_i), .last_i(date_last), .val_o(date_o), .wrap_o(month_adv)
  );

  rtc_wrap_counter #(.FIRST(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .adv_i(month_adv), .ld_i(ld_month_i),
    .ld_data_i(ld_data_i), .last_i(8'h12), .val_o(month_o), .wrap_o(year_adv)
  );

  rtc_wrap_counter #(.FIRST(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .adv_i(year_adv), .ld_i(ld_year_i),
    .ld_data_i(ld_data_i), .last_i(8'h99), .val_o(year_o), .wrap_o(year_wrap_unused)
  );

  always_comb begin
    dow_d = dow_q;
    if (ld_dow_i)   dow_d = ld_data_i[DOW_W-1:0];
    else if (day_i) dow_d = (dow_q == DOW_LAST) ? '0 : dow_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dow_q <= '0;
    else        dow_q <= dow_d;
  end

  assign dow_o = dow_q;

  logic unused_ok;
  assign unused_ok = year_wrap_unused;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int DOW_COUNT = 7,
  localparam int DOW_W = $clog2(DOW_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [DOW_W-1:0]  dow_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o,
  output logic              phase_clr_o
);
  logic [1:0]          rst_pipe_q;
  logic                rst_sync_n;
  logic [NUM_REGS-1:0] ld_vec;
  logic                sec_adv, min_adv, hour_adv, day_adv;
  logic                min_wrap_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ld
    assign ld_vec[gi] = wr_en_i && (wr_sel_i == SEL_W'(gi));
  end

  // A write owns the cycle: the tick is dropped.
  assign sec_adv     = tick_i && !wr_en_i;
  assign phase_clr_o = ld_vec[SEL_SEC];

  rtc_wrap_counter #(.FIRST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_sync_n), .adv_i(sec_adv), .ld_i(ld_vec[SEL_SEC]),
    .ld_data_i(wr_data_i), .last_i(8'h59), .val_o(sec_o), .wrap_o(min_adv)
  );

  rtc_wrap_counter #(.FIRST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_sync_n), .adv_i(min_adv), .ld_i(ld_vec[SEL_MIN]),
    .ld_data_i(wr_data_i), .last_i(8'h59), .val_o(min_o), .wrap_o(hour_adv)
  );

  rtc_hour_counter u_hour (
    .clk(clk), .rst_n(rst_sync_n), .adv_i(hour_adv), .ld_i(ld_vec[SEL_HOUR]),
    .ld_data_i(wr_data_i), .hour_o(hour_o), .day_o(day_adv)
  );

  rtc_calendar #(.DOW_COUNT(DOW_COUNT)) u_cal (
    .clk(clk), .rst_n(rst_sync_n), .day_i(day_adv),
    .ld_dow_i(ld_vec[SEL_DOW]), .ld_date_i(ld_vec[SEL_DATE]),
    .ld_month_i(ld_vec[SEL_MONTH]), .ld_year_i(ld_vec[SEL_YEAR]),
    .ld_data_i(wr_data_i), .dow_o(dow_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o)
  );

  assign min_wrap_unused = 1'b0;
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk #(
  parameter int DOW_COUNT = 7,
  localparam int DOW_W = $clog2(DOW_COUNT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [2:0]       wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       sec_o,
  input logic [7:0]       min_o,
  input logic [7:0]       hour_o,
  input logic [DOW_W-1:0] dow_o,
  input logic [7:0]       date_o,
  input logic [7:0]       month_o,
  input logic [7:0]       year_o,
  input logic             phase_clr_o
);
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && sec_o == 8'h59 |=> sec_o == 8'h00);

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i && !(tick_i && sec_o == 8'h59) |=> $stable(min_o));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_en_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o));

  p_hour24_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hour_o[7] |-> hour_o[5:0] <= 6'h23);

  p_hour12_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hour_o[7] |-> (hour_o[4:0] >= 5'h01) && (hour_o[4:0] <= 5'h12));

  p_month_roll_date_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) && (month_o != $past(month_o)) |-> date_o == 8'h01);

  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) && $past(year_o) == 8'h99 && year_o != 8'h99 |-> year_o == 8'h00);

  p_dow_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dow_o < DOW_W'(DOW_COUNT));

  p_date_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i == 3'd4 |=> date_o == $past(wr_data_i));

  p_write_blocks_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i != 3'd0 |=> $stable(sec_o));

  p_phase_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr_o |=> sec_o == $past(wr_data_i));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.DOW_COUNT(DOW_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
  .year_o(year_o), .phase_clr_o(phase_clr_o)
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic       wr_en_i;
  logic [2:0] wr_sel_i;
  logic [7:0] wr_data_i;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;
  logic       phase_clr_o;

  int n_run  = 0;
  int n_fail = 0;

  // reference state as plain integers
  int m_s, m_m, m_h, m_dow, m_d, m_mo, m_y;
  bit m_24;

  rtc_bcd_core i_rtc_bcd_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o), .phase_clr_o(phase_clr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input bit mode24);
    int h12;
    if (mode24) return 8'h80 | to_bcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return to_bcd(h12) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void model_day();
    m_dow = (m_dow + 1) % 7;
    m_d++;
    if (m_d > days_in(m_mo, m_y)) begin
      m_d = 1;
      m_mo++;
      if (m_mo > 12) begin
        m_mo = 1;
        m_y = (m_y + 1) % 100;
      end
    end
  endfunction

  function automatic void model_tick();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          model_day();
        end
      end
    end
  endfunction

  function automatic void model_write(input logic [2:0] sel, input logic [7:0] d);
    int h12;
    case (sel)
      3'd0: m_s = from_bcd(d);
      3'd1: m_m = from_bcd(d);
      3'd2: begin
        m_24 = d[7];
        if (m_24) m_h = from_bcd({2'b00, d[5:0]});
        else begin
          h12 = from_bcd({3'b000, d[4:0]});
          m_h = (h12 % 12) + (d[5] ? 12 : 0);
        end
      end
      3'd3: m_dow = int'(d[2:0]);
      3'd4: m_d  = from_bcd(d);
      3'd5: m_mo = from_bcd(d);
      3'd6: m_y  = from_bcd(d);
      default: ;
    endcase
  endfunction

  task automatic check_all(input string tag);
    logic [50:0] got, exp;
    got = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    exp = {to_bcd(m_s), to_bcd(m_m), enc_hour(m_h, m_24), 3'(m_dow),
           to_bcd(m_d), to_bcd(m_mo), to_bcd(m_y)};
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // One cycle of stimulus; returns at the negedge after the edge that used it.
  task automatic step(input logic t, input logic w, input logic [2:0] sel,
                      input logic [7:0] d);
    @(negedge clk);
    tick_i = t; wr_en_i = w; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk);
    if (w) model_write(sel, d);
    else if (t) model_tick();
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    step(1'b0, 1'b1, sel, d);
  endtask

  task automatic tick();
    step(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  // Put the time one second before midnight and tick once.
  task automatic roll_day();
    wr(3'd2, enc_hour(23, m_24));
    wr(3'd1, 8'h59);
    wr(3'd0, 8'h59);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 3'd0; wr_data_i = 8'h00;
    m_s = 0; m_m = 0; m_h = 0; m_24 = 1'b0; m_dow = 0; m_d = 1; m_mo = 1; m_y = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset state");

    // R3: idle cycles hold everything
    repeat (5) @(negedge clk);
    check_all("R3 idle hold");

    // R2: seconds and minutes run across two minute wraps
    for (int i = 0; i < 130; i++) begin
      tick();
      check_all("R2 second count");
    end
    repeat (3) @(negedge clk);
    check_all("R3 idle after ticks");

    // R5: twelve-hour sweep over a whole day from 12 AM
    wr(3'd2, 8'h12);
    check_all("R10 hour load");
    for (int i = 0; i < 24; i++) begin
      wr(3'd1, 8'h59);
      wr(3'd0, 8'h59);
      tick();
      check_all("R5 12-hour step");
    end

    // R4: twenty-four-hour sweep over a whole day
    wr(3'd2, 8'h80);
    for (int i = 0; i < 24; i++) begin
      wr(3'd1, 8'h59);
      wr(3'd0, 8'h59);
      tick();
      check_all("R4 24-hour step");
    end

    // R6 R8: every month end for four consecutive years
    for (int y = 0; y < 4; y++) begin
      wr(3'd6, to_bcd(y));
      for (int mo = 1; mo <= 12; mo++) begin
        wr(3'd5, to_bcd(mo));
        wr(3'd4, to_bcd(days_in(mo, y) - 1));
        roll_day();
        check_all("R6 last day reached");
        roll_day();
        check_all("R6 month rollover");
      end
    end

    // R7: February end in all hundred years
    for (int y = 0; y < 100; y++) begin
      wr(3'd6, to_bcd(y));
      wr(3'd5, 8'h02);
      wr(3'd4, 8'h28);
      roll_day();
      check_all("R7 february 28 rollover");
    end

    // R8: year 99 wraps to 00
    wr(3'd6, 8'h99);
    wr(3'd5, 8'h12);
    wr(3'd4, 8'h31);
    roll_day();
    check_all("R8 year wrap");

    // R9: day of week 6 goes to 0
    wr(3'd3, 8'h06);
    roll_day();
    check_all("R9 weekday wrap");

    // R5: 11 PM to 12 AM in twelve-hour form moves the day
    wr(3'd2, 8'h31);
    wr(3'd1, 8'h59);
    wr(3'd0, 8'h59);
    tick();
    check_all("R5 11 PM rollover");
    wr(3'd2, 8'h11);
    wr(3'd1, 8'h59);
    wr(3'd0, 8'h59);
    tick();
    check_all("R5 11 AM to 12 PM");

    // R10: write wins over a same-cycle tick; select 7 is ignored
    wr(3'd0, 8'h59);
    step(1'b1, 1'b1, 3'd3, 8'h05);
    check_all("R10 write beats tick");
    step(1'b1, 1'b1, 3'd7, 8'h42);
    check_all("R10 select 7 ignored");

    // R11: prescaler clear strobe
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 8'h30;
    #1 check_bit("R11 strobe on seconds write", phase_clr_o, 1'b1);
    @(posedge clk); model_write(3'd0, 8'h30);
    @(negedge clk);
    wr_sel_i = 3'd1; wr_data_i = 8'h07;
    #1 check_bit("R11 strobe off for minutes write", phase_clr_o, 1'b0);
    @(posedge clk); model_write(3'd1, 8'h07);
    @(negedge clk);
    wr_en_i = 1'b0;
    #1 check_bit("R11 strobe off when idle", phase_clr_o, 1'b0);
    check_all("R10 loads after strobe test");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule